// File: doc/BRIEF.md
# Free-Run Flat Color Video Generator

This block makes its own video stream on the pixel clock whenever the link should not carry live input. That happens when a software force bit is set, or when the upstream source says it has no valid video. The generated stream is one flat color. Horizontal sync, vertical sync and data enable are framed by a built-in timing set, which a format code selects. When neither condition holds, the live pixel bus and sync signals pass through with one register of delay.

A small write-only register port sets the force bit, the choice between a manual and a built-in default color, three 8-bit channel values and the format code. Color and format changes are held in shadow registers and take effect only at the next frame origin, so one frame never mixes two colors or two timings. Each timing set is a parameter of the top module. The defaults are 640x480 at 60 Hz (format 0) and 1080-line progressive at 60 Hz (format 1).

Top module: `flatcolor_gen`

## Requirements
- R1: While rst_ni is low, de_o is 0 and pix_o is all zeros.
- R2: The generator drives the outputs when the force bit is 1 or in_valid_i is 0. Otherwise pix_o, hs_o, vs_o and de_o equal in_pix_i, in_hs_i, in_vs_i and in_de_i from the previous cycle.
- R3: When the manual bit is 1, the color comes from the three channel registers. When it is 0, a built-in default of green 0x20, red 0x40 and blue 0xC0 is used.
- R4: pix_o is split into three 12-bit channels. Green is at [35:24], red at [23:12] and blue at [11:0]. Each 8-bit value sits in the channel's top 8 bits, and its low 4 bits are zero.
- R5: A write to the color registers or to the manual bit changes the output color only from the next frame origin. The rest of the current frame keeps the old color.
- R6: Each frame has v_act lines, each holding h_act consecutive cycles with de_o high. pix_o is zero in every generated cycle where de_o is low.
- R7: The hsync pulse lasts h_sync cycles and repeats every h_total cycles. The vsync pulse lasts v_sync whole lines. Each pulse drives the active level given by the format's polarity field (1 means active high), and the opposite level otherwise. The default set has both polarities low for format 0 and both high for format 1.
- R8: The format code selects timing set 0 or 1. A new code takes effect only after the current frame ends and the counters return to the frame origin.
- R9: Register map, written when reg_we_i is 1:
  - address 0: bit 0 is force, bit 1 is manual.
  - address 1: green.
  - address 2: red.
  - address 3: blue.
  - address 4: bit 0 is the format code.
  - Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Live input present |
| in_pix_i | input | 36 | Live pixel bus |
| in_hs_i | input | 1 | Live horizontal sync |
| in_vs_i | input | 1 | Live vertical sync |
| in_de_i | input | 1 | Live data enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| pix_o | output | 36 | Output pixel bus |
| hs_o | output | 1 | Output horizontal sync |
| vs_o | output | 1 | Output vertical sync |
| de_o | output | 1 | Output data enable |

## Verification
Some properties are checked by the assertions on every cycle:
- the counters stay inside the line and frame totals and return to the origin after each frame end;
- the shadowed color and format change only on the cycle after a frame end;
- blanking and padding bits stay zero whenever the generator drives the bus;
- the pass-through path copies the input with one cycle of delay.

Other properties only the directed scenarios can show: the measured counts of active pixels, lines, sync widths and periods, the polarity of each format, the default and manual colors, and that a color or format write in mid-frame leaves the current frame untouched. The scenarios also show that writes to unused addresses change nothing.

// File: rtl/frgen_pkg.sv
package frgen_pkg;
  localparam int TW = 12;
  localparam int AW = 3;

  typedef struct packed {
    logic          hpol;
    logic          vpol;
    logic [TW-1:0] h_act;
    logic [TW-1:0] h_fp;
    logic [TW-1:0] h_sync;
    logic [TW-1:0] h_bp;
    logic [TW-1:0] v_act;
    logic [TW-1:0] v_fp;
    logic [TW-1:0] v_sync;
    logic [TW-1:0] v_bp;
  } vtiming_t;

  localparam vtiming_t FMT_VGA = '{hpol: 1'b0, vpol: 1'b0,
    h_act: 12'd640, h_fp: 12'd16, h_sync: 12'd96, h_bp: 12'd48,
    v_act: 12'd480, v_fp: 12'd10, v_sync: 12'd2,  v_bp: 12'd33};

  localparam vtiming_t FMT_HD = '{hpol: 1'b1, vpol: 1'b1,
    h_act: 12'd1920, h_fp: 12'd88, h_sync: 12'd44, h_bp: 12'd148,
    v_act: 12'd1080, v_fp: 12'd4,  v_sync: 12'd5,  v_bp: 12'd36};

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_CHA  = 3'd1;
  localparam logic [AW-1:0] A_FMT  = 3'd4;
endpackage

// File: rtl/frgen_timing.sv
module frgen_timing
  import frgen_pkg::*;
#(
  parameter vtiming_t T0 = FMT_VGA,
  parameter vtiming_t T1 = FMT_HD
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fmt_i,
  output logic de_o,
  output logic hs_o,
  output logic vs_o,
  output logic hpol_o,
  output logic vpol_o,
  output logic frame_end_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  vtiming_t t;
  logic [TW-1:0] h_q, v_q, h_tot, v_tot, hs_beg, hs_end, vs_beg, vs_end;
  logic line_end;

  assign t = fmt_i ? T1 : T0;

  always_comb begin
    hs_beg = t.h_act + t.h_fp;
    hs_end = hs_beg + t.h_sync;
    h_tot  = hs_end + t.h_bp;
    vs_beg = t.v_act + t.v_fp;
    vs_end = vs_beg + t.v_sync;
    v_tot  = vs_end + t.v_bp;
  end

  assign line_end    = (h_q == h_tot - ONE);
  assign frame_end_o = line_end && (v_q == v_tot - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (line_end) begin
      h_q <= '0;
      v_q <= frame_end_o ? '0 : v_q + ONE;
    end else begin
      h_q <= h_q + ONE;
    end
  end

  assign de_o   = (h_q < t.h_act) && (v_q < t.v_act);
  assign hs_o   = (h_q >= hs_beg) && (h_q < hs_end);
  assign vs_o   = (v_q >= vs_beg) && (v_q < vs_end);
  assign hpol_o = t.hpol;
  assign vpol_o = t.vpol;

  p_h_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_q < h_tot) && (v_q < v_tot));

  p_origin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_end_o) |-> (h_q == '0 && v_q == '0));
endmodule

// File: rtl/frgen_regs.sv
module frgen_regs
  import frgen_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int NCH   = 3,
  parameter logic [NCH-1:0][COL_W-1:0] DEF_COL = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [COL_W-1:0]           wdata_i,
  input  logic                       frame_end_i,
  output logic                       force_o,
  output logic                       fmt_o,
  output logic [NCH-1:0][COL_W-1:0]  col_o
);
  logic             man_q, fmt_q, man_l, fmt_l;
  logic [COL_W-1:0] ch_q [NCH];
  logic [COL_W-1:0] ch_l [NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      force_o <= 1'b0;
      man_q   <= 1'b0;
      fmt_q   <= 1'b0;
    end else if (we_i) begin
      if (addr_i == A_CTRL) begin
        force_o <= wdata_i[0];
        man_q   <= wdata_i[1];
      end
      if (addr_i == A_FMT) fmt_q <= wdata_i[0];
    end
  end

  // shadow copies move only at the frame origin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      man_l <= 1'b0;
      fmt_l <= 1'b0;
    end else if (frame_end_i) begin
      man_l <= man_q;
      fmt_l <= fmt_q;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ch_q[i] <= '0;
      else if (we_i && addr_i == AW'(int'(A_CHA) + i))
        ch_q[i] <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           ch_l[i] <= '0;
      else if (frame_end_i)  ch_l[i] <= ch_q[i];
    end

    assign col_o[i] = man_l ? ch_l[i] : DEF_COL[i];
  end

  assign fmt_o = fmt_l;

  p_col_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_end_i) |-> $stable(col_o));

  p_fmt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_end_i) |-> $stable(fmt_o));
endmodule

// File: rtl/frgen_pixel.sv
module frgen_pixel #(
  parameter int COL_W = 8,
  parameter int CH_W  = 12,
  parameter int NCH   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sel_gen_i,
  input  logic                      de_i,
  input  logic                      hs_i,
  input  logic                      vs_i,
  input  logic                      hpol_i,
  input  logic                      vpol_i,
  input  logic [NCH-1:0][COL_W-1:0] col_i,
  input  logic [NCH*CH_W-1:0]       in_pix_i,
  input  logic                      in_hs_i,
  input  logic                      in_vs_i,
  input  logic                      in_de_i,
  output logic [NCH*CH_W-1:0]       pix_o,
  output logic                      hs_o,
  output logic                      vs_o,
  output logic                      de_o
);
  localparam int PAD = CH_W - COL_W;
  localparam int BW  = NCH * CH_W;

  logic [BW-1:0] gen_pix;
  logic          sel_q;

  // channel 0 occupies the top slot of the bus
  for (genvar i = 0; i < NCH; i++) begin : g_slot
    assign gen_pix[(NCH-1-i)*CH_W +: CH_W] = de_i ? {col_i[i], {PAD{1'b0}}} : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b1;
      pix_o <= '0;
      hs_o  <= 1'b0;
      vs_o  <= 1'b0;
      de_o  <= 1'b0;
    end else begin
      sel_q <= sel_gen_i;
      if (sel_gen_i) begin
        pix_o <= gen_pix;
        hs_o  <= hs_i ? hpol_i : ~hpol_i;
        vs_o  <= vs_i ? vpol_i : ~vpol_i;
        de_o  <= de_i;
      end else begin
        pix_o <= in_pix_i;
        hs_o  <= in_hs_i;
        vs_o  <= in_vs_i;
        de_o  <= in_de_i;
      end
    end
  end

  p_blank_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && !de_o) |-> (pix_o == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_pad_chk
    p_pad_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_q |-> (pix_o[(NCH-1-i)*CH_W +: PAD] == '0));
  end
endmodule

// File: rtl/flatcolor_gen.sv
module flatcolor_gen
  import frgen_pkg::*;
#(
  parameter vtiming_t T0    = FMT_VGA,
  parameter vtiming_t T1    = FMT_HD,
  parameter int       COL_W = 8,
  parameter int       CH_W  = 12,
  parameter int       NCH   = 3,
  parameter logic [NCH-1:0][COL_W-1:0] DEF_COL = {8'hC0, 8'h40, 8'h20}
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic [NCH*CH_W-1:0]   in_pix_i,
  input  logic                  in_hs_i,
  input  logic                  in_vs_i,
  input  logic                  in_de_i,
  input  logic                  reg_we_i,
  input  logic [AW-1:0]         reg_addr_i,
  input  logic [COL_W-1:0]      reg_wdata_i,
  output logic [NCH*CH_W-1:0]   pix_o,
  output logic                  hs_o,
  output logic                  vs_o,
  output logic                  de_o
);
  logic force_w, fmt_w, frame_end_w;
  logic t_de, t_hs, t_vs, t_hpol, t_vpol;
  logic [NCH-1:0][COL_W-1:0] col_w;

  frgen_regs #(.COL_W(COL_W), .NCH(NCH), .DEF_COL(DEF_COL)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .frame_end_i(frame_end_w),
    .force_o(force_w), .fmt_o(fmt_w), .col_o(col_w)
  );

  frgen_timing #(.T0(T0), .T1(T1)) u_timing (
    .clk_i, .rst_ni, .fmt_i(fmt_w),
    .de_o(t_de), .hs_o(t_hs), .vs_o(t_vs),
    .hpol_o(t_hpol), .vpol_o(t_vpol), .frame_end_o(frame_end_w)
  );

  frgen_pixel #(.COL_W(COL_W), .CH_W(CH_W), .NCH(NCH)) u_pixel (
    .clk_i, .rst_ni,
    .sel_gen_i(force_w || !in_valid_i),
    .de_i(t_de), .hs_i(t_hs), .vs_i(t_vs),
    .hpol_i(t_hpol), .vpol_i(t_vpol), .col_i(col_w),
    .in_pix_i, .in_hs_i, .in_vs_i, .in_de_i,
    .pix_o, .hs_o, .vs_o, .de_o
  );

  p_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && in_valid_i && !force_w) |->
      (pix_o == $past(in_pix_i) && de_o == $past(in_de_i)));
endmodule

// File: tb/flatcolor_gen_test.sv
module flatcolor_gen_test;
  import frgen_pkg::*;

  localparam vtiming_t TA = '{hpol: 1'b0, vpol: 1'b0,
    h_act: 12'd8,  h_fp: 12'd2, h_sync: 12'd3, h_bp: 12'd3,
    v_act: 12'd4,  v_fp: 12'd1, v_sync: 12'd2, v_bp: 12'd1};
  localparam vtiming_t TB = '{hpol: 1'b1, vpol: 1'b1,
    h_act: 12'd12, h_fp: 12'd2, h_sync: 12'd2, h_bp: 12'd4,
    v_act: 12'd6,  v_fp: 12'd1, v_sync: 12'd1, v_bp: 12'd2};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [35:0] in_pix_i = '0;
  logic        in_hs_i = 1'b0, in_vs_i = 1'b0, in_de_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [35:0] pix_o;
  logic        hs_o, vs_o, de_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  int g_de, g_lines, g_run, g_hsw, g_hsper, g_vscyc, g_mis, g_blank, g_hsbad;
  logic [35:0] g_pix;

  flatcolor_gen #(.T0(TA), .T1(TB)) uut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [35:0] mk(input logic [7:0] g, r, b);
    return {g, 4'h0, r, 4'h0, b, 4'h0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // measures from the end of one vsync pulse to the start of the next
  task automatic grab(input logic hp, vp);
    int cyc, run, last_rise, w;
    logic pde, phs;
    bit first, wdone;
    g_de = 0; g_lines = 0; g_run = 0; g_hsw = 0; g_hsper = 0; g_vscyc = 0;
    g_mis = 0; g_blank = 0; g_hsbad = 0; g_pix = '0;
    while (vs_o == vp) @(negedge clk_i);
    while (vs_o != vp) @(negedge clk_i);
    while (vs_o == vp) begin g_vscyc++; @(negedge clk_i); end
    pde = 1'b0; phs = hs_o; cyc = 0; run = 0; last_rise = -1;
    first = 1; wdone = 0; w = 0;
    while (vs_o != vp) begin
      if (de_o) begin
        g_de++;
        if (!pde) begin g_lines++; run = 0; end
        run++;
        if (run > g_run) g_run = run;
        if (first) begin g_pix = pix_o; first = 0; end
        else if (pix_o != g_pix) g_mis++;
        if (hs_o == hp) g_hsbad++;
      end else if (pix_o != '0) g_blank++;
      if (hs_o == hp && phs != hp) begin
        if (last_rise >= 0) g_hsper = cyc - last_rise;
        last_rise = cyc;
        if (!wdone) w = 0;
      end
      if (hs_o == hp && last_rise >= 0 && !wdone) w++;
      if (hs_o != hp && phs == hp && last_rise >= 0 && !wdone) begin
        g_hsw = w; wdone = 1;
      end
      pde = de_o; phs = hs_o; cyc++;
      @(negedge clk_i);
    end
  endtask

  task automatic check_frame(input vtiming_t t, input logic [35:0] epix);
    int ht;
    ht = int'(t.h_act) + int'(t.h_fp) + int'(t.h_sync) + int'(t.h_bp);
    grab(t.hpol, t.vpol);
    chk(g_lines == int'(t.v_act), "R6 active lines", g_lines, t.v_act);
    chk(g_run == int'(t.h_act), "R6 de run per line", g_run, t.h_act);
    chk(g_de == int'(t.h_act) * int'(t.v_act), "R6 de total", g_de, t.h_act * t.v_act);
    chk(g_blank == 0, "R6 blank pixels zero", g_blank, 0);
    chk(g_hsw == int'(t.h_sync), "R7 hsync width", g_hsw, t.h_sync);
    chk(g_hsper == ht, "R7 hsync period", g_hsper, ht);
    chk(g_vscyc == int'(t.v_sync) * ht, "R7 vsync width", g_vscyc, t.v_sync * ht);
    chk(g_hsbad == 0, "R7 hsync idle level", g_hsbad, 0);
    chk(g_pix == epix, "R3/R4 color", g_pix, epix);
    chk(g_mis == 0, "R5 flat frame", g_mis, 0);
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(negedge clk_i);
      chk(de_o == 1'b0 && pix_o == '0, "R1 reset outputs", {de_o, pix_o}, 0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_default();
    check_frame(TA, mk(8'h20, 8'h40, 8'hC0)); // R3 default, R6, R7
  endtask

  task automatic t_manual();
    wr(3'd1, 8'h12); wr(3'd2, 8'h34); wr(3'd3, 8'h56);
    wr(3'd0, 8'h02);
    grab(TA.hpol, TA.vpol);
    check_frame(TA, mk(8'h12, 8'h34, 8'h56)); // R3 manual, R4 mapping, R9 map
  endtask

  task automatic t_hold();
    int after, bad;
    logic [35:0] old;
    old = mk(8'h12, 8'h34, 8'h56);
    while (!de_o) @(negedge clk_i);
    wr(3'd1, 8'h9A); wr(3'd2, 8'hBC); wr(3'd3, 8'hDE);
    after = 0; bad = 0;
    while (vs_o != TA.vpol) begin
      if (de_o) begin after++; if (pix_o != old) bad++; end
      @(negedge clk_i);
    end
    chk(after > 0, "R5 pixels after write", after, 1);
    chk(bad == 0, "R5 old color held in frame", bad, 0);
    check_frame(TA, mk(8'h9A, 8'hBC, 8'hDE)); // R5 new color next frame
  endtask

  task automatic t_ignored();
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    grab(TA.hpol, TA.vpol);
    check_frame(TA, mk(8'h9A, 8'hBC, 8'hDE)); // R9 unused addresses
  endtask

  task automatic t_format();
    int last, cyc, bad;
    logic phs;
    while (!de_o) @(negedge clk_i);
    wr(3'd4, 8'h01);
    last = -1; cyc = 0; bad = 0; phs = hs_o;
    while (vs_o != TA.vpol) begin
      if (hs_o == TA.hpol && phs != TA.hpol) begin
        if (last >= 0 && cyc - last != 16) bad++;
        last = cyc;
      end
      phs = hs_o; cyc++;
      @(negedge clk_i);
    end
    chk(bad == 0, "R8 old timing until frame end", bad, 0);
    repeat (300) @(negedge clk_i);
    check_frame(TB, mk(8'h9A, 8'hBC, 8'hDE)); // R8 new timing, R7 positive polarity
  endtask

  task automatic t_select();
    in_valid_i = 1'b1;
    in_pix_i = 36'hABC_DE1_234;
    in_de_i = 1'b1; in_hs_i = 1'b0; in_vs_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(pix_o == 36'hABC_DE1_234, "R2 live pixels", pix_o, 36'hABC_DE1_234);
    chk({de_o, hs_o, vs_o} == 3'b101, "R2 live sync", {de_o, hs_o, vs_o}, 3'b101);
    in_pix_i = 36'h123_456_789;
    @(negedge clk_i);
    chk(pix_o == 36'h123_456_789, "R2 one cycle latency", pix_o, 36'h123_456_789);
    wr(3'd0, 8'h03);
    repeat (3) @(negedge clk_i);
    check_frame(TB, mk(8'h9A, 8'hBC, 8'hDE)); // R2 force overrides live input
    wr(3'd0, 8'h02);
    in_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check_frame(TB, mk(8'h9A, 8'hBC, 8'hDE)); // R2 no valid input
  endtask

  initial begin
    t_reset();
    t_default();
    t_manual();
    t_hold();
    t_ignored();
    t_format();
    t_select();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule